// File: doc/BRIEF.md
# Status Packet Sender

The block reports a wide status word downstream as a short burst of bytes on an 8-bit bus. While its enable input asks for reporting, it raises a request and places a fixed address byte on the bus. A downstream consumer answers with a one-cycle acknowledge. That acknowledge accepts the address byte. The block then drives the rest of the packet on the next four consecutive cycles and returns to idle, or it goes straight back to requesting if reporting is still enabled.

The status word is sampled on the clock edge that sees the acknowledge. That sampled copy, and not the live input, feeds every later byte of the packet. The lowest status bits share a byte with a packet sequence number. The sequence number advances once per packet, so the consumer can detect packets that were lost or repeated. The remaining status bits follow in whole bytes, lowest bits first.

Top module: `statusSender`

## Requirements
- R1: While reset (rstN low) is applied, and right after it, pktReq is low and pktData is zero. The first packet after reset carries sequence number 0.
- R2: When sendEn is high while the block is idle, pktReq rises on the next cycle. While pktReq is high, pktData shows the address byte STATUS_ADDR (default 8'hA5), and pktReq stays high until pktAck is seen.
- R3: A pktAck sampled while pktReq is high makes pktReq low from the next cycle on. The four remaining bytes then appear on exactly the next four consecutive cycles.
- R4: The first byte after the address is {sequence number in bits 7:2, status bits 1:0 in bits 1:0}.
- R5: The next three bytes are status[9:2], status[17:10] and status[25:18], in that order, each with the lowest status bit in bit 0.
- R6: The status bytes come from the value statusIn had on the edge that sampled pktAck. Later changes of statusIn do not affect the packet in progress.
- R7: The sequence number is 6 bits wide. It increases by one for every packet sent and wraps from 63 to 0.
- R8: While no request is raised and no packet is in progress, pktData is zero.
- R9: pktReq stays low while the four bytes after the address are driven. With sendEn held high, it rises again on the cycle right after the last byte.
- R10: A pktAck that arrives while pktReq is low is ignored. No bytes are sent, the bus stays zero, and the next packet keeps the sequence number it would have had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sendEn | input | 1 | Level that asks for status packets to be sent |
| statusIn | input | 26 | Status word to report |
| pktAck | input | 1 | Acceptance of the address byte |
| pktReq | output | 1 | Request: a packet is ready and the address byte is on the bus |
| pktData | output | 8 | Byte-serial packet data, zero when idle |

## Verification
A byte index that has gone wrong shows on the very next cycle: the bus carries a byte from the wrong position, or zero in the middle of a packet, or the request rises while the tail bytes should still be flowing. A faulty capture register shows within one to four cycles after the acknowledge, because every byte is compared with the value applied on the acknowledge edge, while statusIn is deliberately scrambled right after that edge. A sequence counter that is off, or that wraps wrongly, shows in the second byte of the next packet. More than 64 packets are checked back to back, so the wrap from 63 to 0 is covered.

// File: rtl/statusPktPkg.sv
package statusPktPkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEND
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;  // sample status on acknowledge
    logic             seqInc;   // last byte driven, advance sequence
    logic             drive;    // bus carries a packet byte
    logic [IDX_W-1:0] byteIdx;  // 0 = address, 1 = sequence byte, 2.. = status bytes
  } ctlStrobes_t;

endpackage

// File: rtl/statusPktCtrl.sv
module statusPktCtrl
  import statusPktPkg::*;
#(
  parameter int PKT_BYTES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sendEn,
  input  logic        pktAck,
  output logic        pktReq,
  output ctlStrobes_t strobes
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  ctlState_e        stateQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (sendEn) stateQ <= ST_REQ;
        end
        ST_REQ: begin
          if (pktAck) begin
            stateQ <= ST_SEND;
            idxQ   <= IDX_W'(1);
          end
        end
        ST_SEND: begin
          if (idxQ == LAST_IDX) begin
            stateQ <= sendEn ? ST_REQ : ST_IDLE;
            idxQ   <= '0;
          end else begin
            idxQ <= idxQ + IDX_W'(1);
          end
        end
        default: begin
          stateQ <= ST_IDLE;
          idxQ   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    pktReq          = (stateQ == ST_REQ);
    strobes.capture = (stateQ == ST_REQ) && pktAck;
    strobes.seqInc  = (stateQ == ST_SEND) && (idxQ == LAST_IDX);
    strobes.drive   = (stateQ != ST_IDLE);
    strobes.byteIdx = (stateQ == ST_SEND) ? idxQ : '0;
  end

endmodule

// File: rtl/statusPktData.sv
module statusPktData
  import statusPktPkg::*;
#(
  parameter int STATUS_W = 26,
  parameter int SEQ_W    = 6,
  parameter int BYTE_W   = 8,
  parameter int NUM_HI   = 3,
  parameter logic [BYTE_W-1:0] ADDR_BYTE = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusIn,
  input  ctlStrobes_t         strobes,
  output logic [BYTE_W-1:0]   pktData
);

  localparam int LOW_W = BYTE_W - SEQ_W;
  localparam int HI_W  = NUM_HI * BYTE_W;

  logic [STATUS_W-1:0] statusQ;
  logic [SEQ_W-1:0]    seqQ;
  logic [HI_W-1:0]     hiBits;
  logic [BYTE_W-1:0]   hiByte [NUM_HI];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      seqQ    <= '0;
    end else begin
      if (strobes.capture) statusQ <= statusIn;
      if (strobes.seqInc)  seqQ    <= seqQ + SEQ_W'(1);
    end
  end

  assign hiBits = HI_W'(statusQ[STATUS_W-1:LOW_W]);

  for (genvar g = 0; g < NUM_HI; g++) begin : gHiByte
    assign hiByte[g] = hiBits[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pktData = '0;
    if (strobes.drive) begin
      if (strobes.byteIdx == '0) begin
        pktData = ADDR_BYTE;
      end else if (strobes.byteIdx == IDX_W'(1)) begin
        pktData = {seqQ, statusQ[LOW_W-1:0]};
      end else begin
        for (int k = 0; k < NUM_HI; k++) begin
          if (strobes.byteIdx == IDX_W'(k + 2)) pktData = hiByte[k];
        end
      end
    end
  end

endmodule

// File: rtl/statusSender.sv
module statusSender
  import statusPktPkg::*;
#(
  parameter int STATUS_W    = 26,
  parameter int SEQ_W       = 6,
  parameter int BYTE_W      = 8,
  parameter int STATUS_ADDR = 'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sendEn,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic                pktAck,
  output logic                pktReq,
  output logic [BYTE_W-1:0]   pktData
);

  localparam int LOW_W     = BYTE_W - SEQ_W;
  localparam int NUM_HI    = (STATUS_W - LOW_W + BYTE_W - 1) / BYTE_W;
  localparam int PKT_BYTES = 2 + NUM_HI;

  ctlStrobes_t strobes;

  statusPktCtrl #(
    .PKT_BYTES(PKT_BYTES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sendEn (sendEn),
    .pktAck (pktAck),
    .pktReq (pktReq),
    .strobes(strobes)
  );

  statusPktData #(
    .STATUS_W (STATUS_W),
    .SEQ_W    (SEQ_W),
    .BYTE_W   (BYTE_W),
    .NUM_HI   (NUM_HI),
    .ADDR_BYTE(BYTE_W'(STATUS_ADDR))
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .statusIn(statusIn),
    .strobes (strobes),
    .pktData (pktData)
  );

endmodule

// File: rtl/statusSenderChk.sv
module statusSenderChk #(
  parameter int STATUS_W    = 26,
  parameter int SEQ_W       = 6,
  parameter int BYTE_W      = 8,
  parameter int STATUS_ADDR = 'hA5
) (
  input logic                clk,
  input logic                rstN,
  input logic [STATUS_W-1:0] statusIn,
  input logic                pktAck,
  input logic                pktReq,
  input logic [BYTE_W-1:0]   pktData
);

  localparam int LOW_W     = BYTE_W - SEQ_W;
  localparam int NUM_HI    = (STATUS_W - LOW_W + BYTE_W - 1) / BYTE_W;
  localparam int HI_W      = NUM_HI * BYTE_W;
  localparam int PKT_BYTES = 2 + NUM_HI;

  logic [3:0]          cnt;     // tail bytes still to come
  logic [SEQ_W-1:0]    expSeq;
  logic [STATUS_W-1:0] capQ;
  logic [HI_W-1:0]     capHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      expSeq <= '0;
      capQ   <= '0;
    end else begin
      if (pktReq && pktAck) begin
        cnt  <= 4'(PKT_BYTES - 1);
        capQ <= statusIn;
      end else if (cnt != '0) begin
        cnt <= cnt - 4'd1;
      end
      if (cnt == 4'd1) expSeq <= expSeq + SEQ_W'(1);
    end
  end

  assign capHi = HI_W'(capQ[STATUS_W-1:LOW_W]);

  AST_ADDR_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    pktReq |-> pktData == BYTE_W'(STATUS_ADDR)); // R2

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    pktReq && pktAck |=> !pktReq); // R3

  AST_NO_REQ_MIDPKT: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0 |-> !pktReq); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cnt == '0 && !pktReq |-> pktData == '0); // R8

  AST_SEQ_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    cnt == 4'(PKT_BYTES - 1) |-> pktData[BYTE_W-1:LOW_W] == expSeq); // R7

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    cnt == 4'(PKT_BYTES - 1) |-> pktData[LOW_W-1:0] == capQ[LOW_W-1:0]); // R4

  AST_LAST_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    cnt == 4'd1 |-> pktData == capHi[HI_W-1 -: BYTE_W]); // R5

endmodule

bind statusSender statusSenderChk #(
  .STATUS_W   (STATUS_W),
  .SEQ_W      (SEQ_W),
  .BYTE_W     (BYTE_W),
  .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .statusIn(statusIn),
  .pktAck  (pktAck),
  .pktReq  (pktReq),
  .pktData (pktData)
);

// File: tb/test_statusSender.sv
module test_statusSender;

  localparam logic [7:0] ADDR = 8'hA5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sendEn = 1'b0;
  logic [25:0] statusIn = '0;
  logic        pktAck = 1'b0;
  logic        pktReq;
  logic [7:0]  pktData;

  int errors = 0;
  int checks = 0;
  int expSeq = 0;
  bit done = 1'b0;

  // {status, ack delay}
  localparam logic [29:0] VECS [6] = '{
    {26'h3FFFFFF, 4'd0},
    {26'h0000000, 4'd1},
    {26'h2AAAAAA, 4'd3},
    {26'h1555555, 4'd2},
    {26'h0000003, 4'd5},
    {26'h3000000, 4'd0}
  };

  always #10 clk = ~clk;

  statusSender i_statusSender (
    .clk     (clk),
    .rstN    (rstN),
    .sendEn  (sendEn),
    .statusIn(statusIn),
    .pktAck  (pktAck),
    .pktReq  (pktReq),
    .pktData (pktData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered at a negedge one cycle before the request is expected
  task automatic doPacket(input logic [25:0] st, input int delay);
    @(negedge clk);
    check("R2 req raised", 32'(pktReq), 32'd1);
    check("R2 address byte", 32'(pktData), 32'(ADDR));
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check("R2 req held", 32'(pktReq), 32'd1);
      check("R2 address held", 32'(pktData), 32'(ADDR));
    end
    statusIn = st;
    pktAck   = 1'b1;
    @(negedge clk);
    pktAck   = 1'b0;
    statusIn = ~st;  // R6: later input changes must not leak into the packet
    check("R3 req dropped", 32'(pktReq), 32'd0);
    check("R4 R7 seq byte", 32'(pktData), 32'({6'(expSeq), st[1:0]}));
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      check("R5 R6 status byte", 32'(pktData), 32'(st[2 + 8*b +: 8]));
      check("R9 no req mid packet", 32'(pktReq), 32'd0);
    end
    expSeq = (expSeq + 1) % 64;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 req in reset", 32'(pktReq), 32'd0);
    check("R1 data in reset", 32'(pktData), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 req after reset", 32'(pktReq), 32'd0);
    check("R8 data idle", 32'(pktData), 32'd0);

    // table of vectors, back to back
    sendEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      doPacket(VECS[i][29:4], int'(VECS[i][3:0]));
    end
    // random status and ack delay, enough packets to wrap the sequence (R7)
    for (int i = 0; i < 70; i++) begin
      doPacket(26'($urandom), int'($urandom_range(0, 4)));
    end
    check("R7 wrap passed", 32'(expSeq), 32'd12);

    // stop reporting: bus returns to zero (R8, R9)
    sendEn = 1'b0;
    @(negedge clk);
    check("R9 no req when disabled", 32'(pktReq), 32'd0);
    check("R8 bus zero when idle", 32'(pktData), 32'd0);

    // R10: acknowledge while idle is ignored
    statusIn = 26'h1234567;
    pktAck   = 1'b1;
    @(negedge clk);
    pktAck = 1'b0;
    check("R10 no req after stray ack", 32'(pktReq), 32'd0);
    check("R10 bus zero after stray ack", 32'(pktData), 32'd0);
    @(negedge clk);
    check("R10 bus still zero", 32'(pktData), 32'd0);
    sendEn = 1'b1;
    doPacket(26'h0ABCDEF, 1);  // sequence must be unchanged by the stray ack
    sendEn = 1'b0;
    @(negedge clk);
    check("R8 idle after packet", 32'(pktData), 32'd0);

    // R1: reset restarts the sequence at zero
    rstN = 1'b0;
    @(negedge clk);
    check("R1 req in second reset", 32'(pktReq), 32'd0);
    check("R1 data in second reset", 32'(pktData), 32'd0);
    rstN   = 1'b1;
    expSeq = 0;
    sendEn = 1'b1;
    doPacket(26'h2C0FFEE, 0);
    sendEn = 1'b0;
    @(negedge clk);
    check("R8 final idle", 32'(pktData), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule